// File: doc/BRIEF.md
# Serial Byte Sink with Receive Queue

This block lets an external host push a byte stream into the chip over a three-wire, receive-only synchronous serial link. The host drives a bit clock, a framing strobe and a data line. None of the three is related to the system clock. Each bit is taken on a rising edge of the bit clock, and bits are packed most-significant first into bytes. The host may only change the data line on the falling edge.

A rising edge on the framing strobe, made while the bit clock is low, marks the start of a byte. It also throws away any partly received byte. After that, every eight bits close a byte and a new one begins, without any further strobe. Finished bytes go into a 256-entry byte queue. Internal logic drains the queue through a show-ahead read port: the oldest byte is always visible, and a pop strobe removes it.

An active-low request output tells the host that the queue is running low, so the host can send in bursts. If a byte completes while the queue is full, that byte is dropped and a sticky overflow flag is set. The three link inputs are oversampled by the system clock, which must run at least four times faster than the bit clock.

Top module: `serial_byte_sink`

## Requirements
- R1: Each data bit is the value of `sdata_i` at a rising edge of `sclk_i`. A change of `sdata_i` while `sclk_i` is high, at least one system clock after the rise, does not alter the received byte.
- R2: The first bit after framing becomes bit 7 of the byte and the eighth bit becomes bit 0 (most significant bit first).
- R3: A rising edge of `frame_i` while `sclk_i` is low discards any partial byte. The next `sclk_i` rise carries bit 7 of a new byte.
- R4: After eight bits a byte is complete and the next bit starts a new byte, with no further framing edge.
- R5: The queue stores up to 256 bytes in arrival order. When `empty_o` is 0, `rd_data_o` shows the oldest byte, and a cycle with `pop_i` high removes it.
- R6: `more_req_n_o` is 0 while the queue holds fewer than 64 bytes and 1 while it holds 64 or more.
- R7: A byte completed while 256 bytes are stored is dropped and the stored bytes are unchanged. `overflow_o` becomes 1 and stays 1 until reset.
- R8: `pop_i` while `empty_o` is 1 has no effect. The next received byte is the next byte read.
- R9: After reset, `empty_o` is 1, `more_req_n_o` is 0 and `overflow_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Host bit clock, asynchronous |
| frame_i | input | 1 | Host framing strobe, asynchronous; a rising edge starts a byte |
| sdata_i | input | 1 | Host serial data, asynchronous |
| pop_i | input | 1 | Remove the oldest queued byte |
| rd_data_o | output | 8 | Oldest queued byte |
| empty_o | output | 1 | Queue holds no bytes |
| more_req_n_o | output | 1 | Active low: queue holds fewer than 64 bytes |
| overflow_o | output | 1 | Sticky: a byte was dropped because the queue was full |

## Verification
The assertions check on every cycle that:
- the fill count never exceeds 256;
- a byte arriving at a full queue sets the overflow flag and leaves the write side untouched;
- the overflow flag never clears;
- a pop on an empty queue leaves the read side untouched;
- the request line only goes active after a pop;
- a framing edge always restarts the bit position.

Bit order, the immunity of a byte to data changes while the bit clock is high, discarding of partial bytes, byte boundaries without a framing edge, and the exact 63/64 threshold show only in the bench's scenarios. In those scenarios, serial streams are compared with the bytes read back from the queue.

// File: rtl/serial_byte_sink.sv
module serial_byte_sink #(
  parameter int DEPTH       = 256,
  parameter int LOW_MARK    = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk_i,
  input  logic       frame_i,
  input  logic       sdata_i,
  input  logic       pop_i,
  output logic [7:0] rd_data_o,
  output logic       empty_o,
  output logic       more_req_n_o,
  output logic       overflow_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [SYNC_STAGES-1:0] sclk_sr, frame_sr, sdat_sr;
  logic sclk_d, frame_d;
  logic [2:0] bit_cnt;
  logic [6:0] shift_q;
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic [7:0] mem [DEPTH];

  wire sclk_s  = sclk_sr[SYNC_STAGES-1];
  wire frame_s = frame_sr[SYNC_STAGES-1];
  wire sdat_s  = sdat_sr[SYNC_STAGES-1];
  wire sclk_rise  = sclk_s & ~sclk_d;
  wire frame_rise = frame_s & ~frame_d;
  wire byte_done  = sclk_rise & ~frame_rise & (bit_cnt == 3'd7);
  wire full       = (count == CW'(DEPTH));
  wire push       = byte_done & ~full;
  wire pop        = pop_i & ~empty_o;

  assign empty_o      = (count == '0);
  assign more_req_n_o = (count >= CW'(LOW_MARK));
  assign rd_data_o    = mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_sr  <= '0;
      frame_sr <= '0;
      sdat_sr  <= '0;
      sclk_d   <= 1'b0;
      frame_d  <= 1'b0;
    end else begin
      sclk_sr  <= {sclk_sr[SYNC_STAGES-2:0], sclk_i};
      frame_sr <= {frame_sr[SYNC_STAGES-2:0], frame_i};
      sdat_sr  <= {sdat_sr[SYNC_STAGES-2:0], sdata_i};
      sclk_d   <= sclk_s;
      frame_d  <= frame_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      shift_q <= '0;
    end else if (frame_rise) begin
      bit_cnt <= '0;
      shift_q <= '0;
    end else if (sclk_rise) begin
      bit_cnt <= bit_cnt + 3'd1;
      shift_q <= {shift_q[5:0], sdat_s};
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= {shift_q, sdat_s};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr     <= '0;
      rd_ptr     <= '0;
      count      <= '0;
      overflow_o <= 1'b0;
    end else begin
      if (push) wr_ptr <= wr_ptr + AW'(1);
      if (pop)  rd_ptr <= rd_ptr + AW'(1);
      if (push && !pop)      count <= count + CW'(1);
      else if (pop && !push) count <= count - CW'(1);
      if (byte_done && full) overflow_o <= 1'b1;
    end
  end

  assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  assert_full_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && full) |=> (overflow_o && $stable(wr_ptr)));
  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_o |=> overflow_o);
  assert_empty_pop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && empty_o) |=> $stable(rd_ptr));
  assert_req_after_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(more_req_n_o) |-> $past(pop_i));
  assert_frame_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_rise |=> (bit_cnt == 3'd0));
endmodule

// File: tb/tb_serial_byte_sink.sv
module tb_serial_byte_sink;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk_i = 1'b0, frame_i = 1'b0, sdata_i = 1'b0, pop_i = 1'b0;
  logic [7:0] rd_data_o;
  logic empty_o, more_req_n_o, overflow_o;

  int checks = 0, failures = 0;
  logic [7:0] model_q[$];
  logic exp_ovf = 1'b0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  serial_byte_sink dut (.clk(clk), .rst_n(rst_n), .sclk_i(sclk_i), .frame_i(frame_i),
    .sdata_i(sdata_i), .pop_i(pop_i), .rd_data_o(rd_data_o), .empty_o(empty_o),
    .more_req_n_o(more_req_n_o), .overflow_o(overflow_o));

  function automatic logic exp_req_n(int n);
    return (n >= 64);
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_bit(logic b, logic corrupt);
    sdata_i = b;
    tick(3);
    sclk_i = 1'b1;
    if (corrupt) begin tick(2); sdata_i = ~b; tick(1); end
    else tick(3);
    sclk_i = 1'b0;
  endtask

  task automatic frame_pulse();
    frame_i = 1'b1; tick(3);
    frame_i = 1'b0; tick(3);
  endtask

  task automatic send_byte(logic [7:0] b, logic corrupt);
    for (int i = 7; i >= 0; i--) send_bit(b[i], corrupt);
    if (model_q.size() < 256) model_q.push_back(b);
    else exp_ovf = 1'b1;
  endtask

  task automatic pop_check(string tag);
    chk({tag, " empty"}, empty_o, 0);
    chk({tag, " data"}, rd_data_o, model_q[0]);
    pop_i = 1'b1; tick(1); pop_i = 1'b0;
    void'(model_q.pop_front());
  endtask

  task automatic drain(string tag);
    while (model_q.size() > 0) pop_check(tag);
    tick(1);
    chk({tag, " drained empty"}, empty_o, 1);
  endtask

  initial begin
    #150000000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    tick(3);
    chk("R9 empty after reset", empty_o, 1);
    chk("R9 req after reset", more_req_n_o, 0);
    chk("R9 ovf after reset", overflow_o, 0);
    rst_n = 1'b1;
    tick(3);

    // R2/R5: directed MSB-first byte then random bytes
    frame_pulse();
    send_byte(8'h81, 1'b0);
    tick(6);
    chk("R2 msb first", rd_data_o, 8'h81);
    for (int k = 0; k < 6; k++) send_byte(8'($urandom), 1'b0);
    tick(6);
    chk("R5 count via req", more_req_n_o, exp_req_n(model_q.size()));
    drain("R5 random order");

    // R1: data flipped while clock high
    frame_pulse();
    for (int k = 0; k < 4; k++) send_byte(8'($urandom), 1'b1);
    send_byte(8'h5A, 1'b1);
    tick(6);
    drain("R1 corrupt while high");

    // R3: partial byte discarded by new framing edge
    frame_pulse();
    send_bit(1'b1, 1'b0); send_bit(1'b0, 1'b0); send_bit(1'b1, 1'b0);
    tick(4);
    chk("R3 partial not stored", empty_o, 1);
    frame_pulse();
    send_byte(8'h3C, 1'b0);
    tick(6);
    chk("R3 realigned byte", rd_data_o, 8'h3C);
    drain("R3");

    // R4: back-to-back bytes with no framing edge
    send_byte(8'hF0, 1'b0);
    send_byte(8'h0F, 1'b0);
    send_byte(8'hC3, 1'b0);
    tick(6);
    drain("R4 continuous");

    // R8: pop on empty ignored
    pop_i = 1'b1; tick(3); pop_i = 1'b0; tick(1);
    chk("R8 still empty", empty_o, 1);
    chk("R8 req unchanged", more_req_n_o, 0);
    send_byte(8'hA5, 1'b0);
    tick(6);
    chk("R8 next byte read", rd_data_o, 8'hA5);
    drain("R8");

    // R6: threshold at 63/64
    for (int k = 0; k < 63; k++) send_byte(8'($urandom), 1'b0);
    tick(6);
    chk("R6 63 bytes req low", more_req_n_o, 0);
    send_byte(8'($urandom), 1'b0);
    tick(6);
    chk("R6 64 bytes req high", more_req_n_o, 1);
    pop_check("R6 pop");
    tick(1);
    chk("R6 63 after pop req low", more_req_n_o, 0);

    // R7: fill to 256, then overflow
    while (model_q.size() < 256) send_byte(8'($urandom), 1'b0);
    tick(6);
    chk("R7 no ovf at full", overflow_o, 0);
    send_byte(8'hEE, 1'b0);
    send_byte(8'h11, 1'b0);
    tick(6);
    chk("R7 ovf set", overflow_o, exp_ovf);
    drain("R7 contents kept");
    chk("R7 ovf sticky", overflow_o, 1);
    chk("R6 req low when empty", more_req_n_o, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule